// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the D+ and D- lines of a low-speed USB link into a stream of decoded bytes. It runs on a local clock of roughly eight times the 1.5 Mb/s bit rate. Both lines pass through a two-stage synchronizer. A phase counter is reset on every transition of D-, which places the sample point near the middle of each bit even when the local clock is up to one percent off nominal.

From idle, the receiver arms on a transition from J to K and then qualifies the sync field. Receive starts only after two K bits in a row. A K followed by a J sends the block back to searching for the next J-to-K edge. A bounded search window keeps a broken sync from hanging the block. Once in a packet, the receiver does the following:
- it decodes NRZI;
- it drops stuffed zeros;
- it assembles bytes least significant bit first;
- it pulses a valid strobe for each byte.

The packet ends with a single completion pulse and a status code. The code reports a clean end of packet, a byte-limit overflow, a stuffing violation or a sync timeout. PID, CRC and address checks are left to the logic downstream.

Top module: `usbrx_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `rx_valid`, `rx_done` and `rx_active` are 0, `rx_status` is 0 and `rx_data` is 0.
- R2: The line levels are encoded as follows: J is D+=0, D-=1; K is D+=1, D-=0; SE0 is both lines low. A J-to-K edge arms the receiver. Packet reception starts only when two consecutive bit samples read K. A K sample followed by a non-K sample returns the block to waiting for the next J-to-K edge, and a later valid sync is still received.
- R3: Each bit is NRZI-decoded: the same D- level as the previous bit gives 1, and a changed level gives 0. The first data bit is compared against the final K of sync. Every eight data bits form one byte, first received bit in bit 0. Each byte is presented on `rx_data` with a `rx_valid` pulse of exactly one cycle.
- R4: A 1-run counter starts at 1 after sync, because the last sync bit counts. After six consecutive decoded 1s, the next bit is discarded and never enters a byte.
- R5: If the bit that should be stuffed decodes as 1, the packet ends with `rx_done` and status 2. No further bytes are delivered until an SE0 has been seen, after which the receiver re-arms.
- R6: An SE0 at a bit sample point ends a packet in progress. This produces one `rx_done` pulse with status 0. Any bits of an incomplete byte are discarded without a `rx_valid` pulse.
- R7: A packet delivers at most `byte_limit` bytes. When one more byte completes, that byte is not delivered and the packet ends with `rx_done` and status 1.
- R8: If reception has not started within `SYNC_TIMEOUT` clocks of the first J-to-K edge after idle, the block ends with `rx_done` and status 3 and returns to idle.
- R9: Packets are decoded correctly when the line bit period is 1% longer or 1% shorter than eight local clocks.
- R10: `rx_active` is high from the end of sync until the packet ends. It is high at every `rx_valid` and low at every `rx_done`.
- R11: `rx_valid` and `rx_done` never coincide, and `rx_status` changes only in a cycle where `rx_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, about 8x bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Raw D+ line level |
| line_dm | input | 1 | Raw D- line level |
| byte_limit | input | LIMIT_W | Largest number of bytes accepted per packet |
| rx_data | output | 8 | Decoded byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_done | output | 1 | One-cycle packet completion pulse |
| rx_status | output | 2 | 0 ok, 1 overflow, 2 stuff error, 3 sync timeout |
| rx_active | output | 1 | Packet reception in progress |

## Verification
The bench covers the following corner cases:
- A single false K ahead of sync. A receiver that accepted one K as sync would deliver shifted garbage bytes.
- Runs of 0xFF. These force stuffed zeros across byte boundaries, so a receiver that mishandled the inherited 1 from sync would lose byte alignment.
- A deliberately unstuffed run, which must report a stuffing error instead of emitting bytes.
- A trailing partial byte, which must never produce a strobe.
- Byte limits of zero, exact and one short, which catch an off-by-one in the overflow compare.
- A lone K that never completes sync, which checks that the timeout fires instead of leaving the block stuck.
- Packets at plus and minus one percent bit period. These would slip a bit if the phase were not re-centred on D- edges.

// File: rtl/usbrx_pkg.sv
`timescale 1ns/1ps
// Shared types for the low-speed USB receiver.
package usbrx_pkg;

    // Completion codes reported with rx_done.
    typedef enum logic [1:0] {
        RX_OK        = 2'd0,
        RX_OVERFLOW  = 2'd1,
        RX_STUFF_ERR = 2'd2,
        RX_TIMEOUT   = 2'd3
    } rx_status_t;

    // Receiver control states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SYNC,
        ST_RECV,
        ST_DRAIN
    } rx_state_t;

    // Synchronized line pair; dm is the low bit.
    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

endpackage

// File: rtl/usbrx_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous line inputs.
// Assumes inputs are slow relative to clk (at least several clocks per level).
module usbrx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the raw inputs through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
        end else begin
            stage[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign d_out = stage[STAGES-1];
endmodule

// File: rtl/usbrx_dpll.sv
`timescale 1ns/1ps
// Bit-timing recovery: a phase counter that restarts on every D- transition
// and raises a sample strobe near the middle of each bit. Also flags J-to-K
// edges for sync search. Assumes OVS local clocks per bit, OVS >= 4.
module usbrx_dpll
    import usbrx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line,
    output logic  strobe,
    output logic  jk_edge
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] SAMPLE_AT = PW'(OVS / 2 - 1);
    localparam logic [PW-1:0] LAST      = PW'(OVS - 1);

    logic          dm_q;
    logic [PW-1:0] phase;
    logic          dm_edge;

    assign dm_edge = line.dm ^ dm_q;

    // Track previous D- level and advance or restart the bit phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_q  <= 1'b1;
            phase <= '0;
        end else begin
            dm_q <= line.dm;
            if (dm_edge)            phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + 1'b1;
        end
    end

    assign strobe  = (phase == SAMPLE_AT) && !dm_edge;
    assign jk_edge = dm_q && !line.dm && line.dp;
endmodule

// File: rtl/usbrx_decoder.sv
`timescale 1ns/1ps
// Packet control: sync qualification with timeout, NRZI decode, stuffed-bit
// removal, byte assembly, byte-limit check and end-of-packet reporting.
// Assumes strobe marks one bit centre per bit and line is synchronized.
module usbrx_decoder
    import usbrx_pkg::*;
#(
    parameter int LIMIT_W      = 8,
    parameter int SYNC_TIMEOUT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic               jk_edge,
    input  line_t              line,
    input  logic [LIMIT_W-1:0] byte_limit,
    output logic [7:0]         data,
    output logic               valid,
    output logic               done,
    output rx_status_t         status,
    output logic               active
);
    localparam int TW = $clog2(SYNC_TIMEOUT + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(SYNC_TIMEOUT - 1);
    localparam logic [2:0] RUN_MAX = 3'd6;

    rx_state_t          state;
    logic               k_seen;
    logic [TW-1:0]      tmo;
    logic               prev_dm;
    logic [2:0]         ones;
    logic [2:0]         bitcnt;
    logic [7:0]         shreg;
    logic [LIMIT_W-1:0] nbytes;

    logic       is_k, is_se0, nrzi_bit;
    logic [7:0] next_byte;

    assign is_k      = line.dp & ~line.dm;
    assign is_se0    = ~line.dp & ~line.dm;
    assign nrzi_bit  = (line.dm == prev_dm);
    assign next_byte = {nrzi_bit, shreg[7:1]};
    assign active    = (state == ST_RECV);

    // Main receive sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            k_seen  <= 1'b0;
            tmo     <= '0;
            prev_dm <= 1'b1;
            ones    <= '0;
            bitcnt  <= '0;
            shreg   <= '0;
            nbytes  <= '0;
            data    <= '0;
            valid   <= 1'b0;
            done    <= 1'b0;
            status  <= RX_OK;
        end else begin
            valid <= 1'b0;
            done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (jk_edge) begin
                        state  <= ST_SYNC;
                        k_seen <= 1'b0;
                        tmo    <= '0;
                    end
                end
                ST_HUNT, ST_SYNC: begin
                    tmo <= tmo + 1'b1;
                    if (tmo == TMO_LAST) begin
                        done   <= 1'b1;
                        status <= RX_TIMEOUT;
                        state  <= ST_IDLE;
                    end else if (state == ST_HUNT) begin
                        if (jk_edge) begin
                            state  <= ST_SYNC;
                            k_seen <= 1'b0;
                        end
                    end else if (strobe) begin
                        if (!is_k) begin
                            state <= ST_HUNT;
                        end else if (k_seen) begin
                            state   <= ST_RECV;
                            prev_dm <= 1'b0;
                            ones    <= 3'd1;
                            bitcnt  <= '0;
                            nbytes  <= '0;
                        end else begin
                            k_seen <= 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (strobe) begin
                        if (is_se0) begin
                            done   <= 1'b1;
                            status <= RX_OK;
                            state  <= ST_IDLE;
                        end else begin
                            prev_dm <= line.dm;
                            if (ones == RUN_MAX) begin
                                if (nrzi_bit) begin
                                    done   <= 1'b1;
                                    status <= RX_STUFF_ERR;
                                    state  <= ST_DRAIN;
                                end else begin
                                    ones <= '0;
                                end
                            end else begin
                                shreg  <= next_byte;
                                ones   <= nrzi_bit ? ones + 3'd1 : 3'd0;
                                bitcnt <= bitcnt + 3'd1;
                                if (bitcnt == 3'd7) begin
                                    if (nbytes == byte_limit) begin
                                        done   <= 1'b1;
                                        status <= RX_OVERFLOW;
                                        state  <= ST_DRAIN;
                                    end else begin
                                        valid  <= 1'b1;
                                        data   <= next_byte;
                                        nbytes <= nbytes + 1'b1;
                                    end
                                end
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (strobe && is_se0) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbrx_top.sv
`timescale 1ns/1ps
// Low-speed USB receiver top: synchronizer, bit-timing recovery and decoder.
// Assumes clk runs near OVS times the line bit rate.
module usbrx_top
    import usbrx_pkg::*;
#(
    parameter int OVS          = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int SYNC_TIMEOUT = 128,
    parameter int LIMIT_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_dp,
    input  logic               line_dm,
    input  logic [LIMIT_W-1:0] byte_limit,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic               rx_done,
    output logic [1:0]         rx_status,
    output logic               rx_active
);
    logic [1:0] sync_q;
    line_t      s_line;
    logic       strobe, jk_edge;
    rx_status_t status;

    usbrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({line_dp, line_dm}), .d_out(sync_q)
    );

    assign s_line = sync_q;

    usbrx_dpll #(.OVS(OVS)) u_dpll (
        .clk(clk), .rst_n(rst_n), .line(s_line), .strobe(strobe), .jk_edge(jk_edge)
    );

    usbrx_decoder #(.LIMIT_W(LIMIT_W), .SYNC_TIMEOUT(SYNC_TIMEOUT)) u_dec (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .jk_edge(jk_edge), .line(s_line),
        .byte_limit(byte_limit), .data(rx_data), .valid(rx_valid), .done(rx_done),
        .status(status), .active(rx_active)
    );

    assign rx_status = status;
endmodule

// File: rtl/usbrx_checker.sv
`timescale 1ns/1ps
// Protocol checks on the receiver's output interface.
module usbrx_checker #(
    parameter int LIMIT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_valid,
    input logic               rx_done,
    input logic [1:0]         rx_status,
    input logic               rx_active,
    input logic [LIMIT_W-1:0] byte_limit
);
    logic [LIMIT_W:0] nvalid;

    // Count bytes delivered in the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_done) nvalid <= '0;
        else if (rx_valid)     nvalid <= nvalid + 1'b1;
    end

    AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_valid && rx_done)); // R11
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> !rx_done); // R6
    AST_VALID_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> rx_active); // R10
    AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> !rx_active); // R10
    AST_STATUS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_status) |-> rx_done); // R11
    AST_TIMEOUT_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && rx_status == 2'd3) |-> !$past(rx_active)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> ({1'b0, byte_limit} > nvalid)); // R7
endmodule

bind usbrx_top usbrx_checker #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_done(rx_done),
    .rx_status(rx_status), .rx_active(rx_active), .byte_limit(byte_limit)
);

// File: tb/usbrx_top_test.sv
`timescale 1ns/1ps
module usbrx_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_dp = 1'b0;
    logic       line_dm = 1'b1;
    logic [7:0] byte_limit = 8'd8;
    logic [7:0] rx_data;
    logic       rx_valid, rx_done, rx_active;
    logic [1:0] rx_status;

    int checks = 0;
    int fails  = 0;

    usbrx_top uut (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
        .byte_limit(byte_limit), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_done(rx_done), .rx_status(rx_status), .rx_active(rx_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Output monitor, sampled on the falling edge.
    logic [7:0] cap [0:1023];
    int         cap_n = 0;
    int         done_n = 0;
    int         act_bad = 0;
    int         both_n = 0;
    logic [1:0] last_status = 2'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (cap_n < 1024) cap[cap_n] = rx_data;
                cap_n++;
                if (!rx_active) act_bad++;
            end
            if (rx_done) begin
                done_n++;
                last_status = rx_status;
            end
            if (rx_valid && rx_done) both_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Line symbol builder: {dp,dm}; J=01, K=10, SE0=00.
    logic [1:0] sym [0:2047];
    int         nsym;
    bit         lvl;
    int         ones;
    logic [7:0] exp_b [0:63];
    int         exp_n;

    task automatic push(input logic [1:0] s);
        sym[nsym] = s;
        nsym++;
    endtask

    task automatic put_nrzi(input bit b);
        if (!b) lvl = ~lvl;
        push(lvl ? 2'b01 : 2'b10);
    endtask

    task automatic clear_line();
        nsym = 0;
        lvl  = 1'b1;
        push(2'b01);
        push(2'b01);
    endtask

    task automatic put_sync();
        for (int i = 0; i < 7; i++) put_nrzi(1'b0);
        put_nrzi(1'b1);
        ones = 1;
    endtask

    task automatic put_bit(input bit b, input bit stuff_en);
        put_nrzi(b);
        ones = b ? ones + 1 : 0;
        if (stuff_en && ones == 6) begin
            put_nrzi(1'b0);
            ones = 0;
        end
    endtask

    task automatic put_byte(input logic [7:0] v, input bit stuff_en);
        for (int i = 0; i < 8; i++) put_bit(v[i], stuff_en);
    endtask

    task automatic put_eop();
        push(2'b00);
        push(2'b00);
        lvl = 1'b1;
        for (int i = 0; i < 3; i++) push(2'b01);
    endtask

    // Drive the built symbols, wait for the decoder, then check the packet.
    task automatic run_packet(input real skew, input int limit, input int exp_status,
                              input string req);
        real bitper;
        int  base_cap, base_done;
        bitper = 80.0 * (1.0 + skew);
        byte_limit = 8'(limit);
        base_cap  = cap_n;
        base_done = done_n;
        for (int i = 0; i < nsym; i++) begin
            {line_dp, line_dm} = sym[i];
            #(bitper);
        end
        {line_dp, line_dm} = 2'b01;
        repeat (200) @(negedge clk);
        check(done_n - base_done == 1, req, "one completion per packet (R6)", done_n - base_done, 1);
        check(last_status == 2'(exp_status), req, "completion status", last_status, exp_status);
        check(cap_n - base_cap == exp_n, req, "byte count", cap_n - base_cap, exp_n);
        for (int i = 0; i < exp_n && i < cap_n - base_cap; i++)
            check(cap[base_cap + i] == exp_b[i], req, $sformatf("byte %0d", i), cap[base_cap + i], exp_b[i]);
        check(rx_active == 1'b0, "R10", "active low after packet", rx_active, 0);
    endtask

    task automatic load_exp(input int n, input logic [7:0] v0, input logic [7:0] v1,
                            input logic [7:0] v2);
        exp_n = n;
        exp_b[0] = v0;
        exp_b[1] = v1;
        exp_b[2] = v2;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [7:0]  rb;
        int          len;
        real         sk;
        seed = $urandom(32'd20240611);
        #1;
        repeat (4) @(negedge clk);
        check(rx_valid == 0 && rx_done == 0 && rx_active == 0, "R1", "flags in reset",
              {rx_valid, rx_done, rx_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_status == 0 && rx_data == 0, "R1", "status and data after reset",
              {rx_status, rx_data}, 0);
        repeat (4) @(negedge clk);

        // R2 R3: basic packet
        clear_line(); put_sync(); put_byte(8'hC3, 1); put_byte(8'h5A, 1); put_eop();
        load_exp(2, 8'hC3, 8'h5A, 8'h00);
        run_packet(0.0, 8, 0, "R3");

        // R4: long runs of ones need stuffed zeros across byte boundaries
        clear_line(); put_sync(); put_byte(8'hFF, 1); put_byte(8'hFF, 1); put_byte(8'h3F, 1); put_eop();
        load_exp(3, 8'hFF, 8'hFF, 8'h3F);
        run_packet(0.0, 8, 0, "R4");

        // R2: one false K before sync
        clear_line(); push(2'b10); push(2'b01); push(2'b01); push(2'b01);
        lvl = 1'b1; put_sync(); put_byte(8'hA5, 1); put_eop();
        load_exp(1, 8'hA5, 8'h00, 8'h00);
        run_packet(0.0, 8, 0, "R2");

        // R6: trailing partial byte is discarded
        clear_line(); put_sync(); put_byte(8'h12, 1); put_bit(1'b0, 1); put_bit(1'b1, 1); put_bit(1'b0, 1); put_eop();
        load_exp(1, 8'h12, 8'h00, 8'h00);
        run_packet(0.0, 8, 0, "R6");

        // R7: limit exceeded, zero limit, exact limit
        clear_line(); put_sync(); put_byte(8'h01, 1); put_byte(8'h02, 1); put_byte(8'h03, 1); put_eop();
        load_exp(2, 8'h01, 8'h02, 8'h00);
        run_packet(0.0, 2, 1, "R7");
        clear_line(); put_sync(); put_byte(8'h77, 1); put_eop();
        load_exp(0, 8'h00, 8'h00, 8'h00);
        run_packet(0.0, 0, 1, "R7");
        clear_line(); put_sync(); put_byte(8'h01, 1); put_byte(8'h02, 1); put_byte(8'h03, 1); put_eop();
        load_exp(3, 8'h01, 8'h02, 8'h03);
        run_packet(0.0, 3, 0, "R7");

        // R5: seven ones without a stuffed zero, then recovery
        clear_line(); put_sync(); put_byte(8'hFF, 0); put_byte(8'hFF, 0); put_eop();
        load_exp(0, 8'h00, 8'h00, 8'h00);
        run_packet(0.0, 8, 2, "R5");
        clear_line(); put_sync(); put_byte(8'h3C, 1); put_eop();
        load_exp(1, 8'h3C, 8'h00, 8'h00);
        run_packet(0.0, 8, 0, "R5");

        // R8: a lone K never completes sync
        clear_line(); push(2'b10);
        for (int i = 0; i < 30; i++) push(2'b01);
        load_exp(0, 8'h00, 8'h00, 8'h00);
        run_packet(0.0, 8, 3, "R8");

        // R9: clock error of plus and minus one percent
        clear_line(); put_sync();
        for (int i = 0; i < 4; i++) begin put_byte(8'h00, 1); put_byte(8'hFF, 1); end
        put_eop();
        exp_n = 8;
        for (int i = 0; i < 8; i++) exp_b[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
        run_packet(0.01, 8, 0, "R9");
        run_packet(-0.01, 8, 0, "R9");

        // Random packets with random clock error
        for (int p = 0; p < 24; p++) begin
            len = 1 + int'($urandom % 6);
            sk  = (real'(int'($urandom % 3)) - 1.0) * 0.01;
            clear_line(); put_sync();
            for (int i = 0; i < len; i++) begin
                rb = 8'($urandom);
                exp_b[i] = rb;
                put_byte(rb, 1);
            end
            put_eop();
            exp_n = len;
            run_packet(sk, 8, 0, "R3");
        end

        check(act_bad == 0, "R10", "valid while inactive", act_bad, 0);
        check(both_n == 0, "R11", "valid and done together", both_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule